// File: doc/BRIEF.md
# Debug Serial Port with Status Flags

This block is a small memory-mapped serial port for console and debug traffic. A 32-bit register bus with single-cycle select, write-enable and a six-bit byte address reaches nine registers: control, mode, interrupt set, interrupt clear, interrupt mask, status, receive holding, transmit holding and baud divisor. The port has one transmit holding byte and one receive holding byte, with no FIFO. It sends 8N1 frames on `tx_o` and receives them on `rx_i`. The level interrupt `irq_o` follows the mask ANDed with the status word, so it changes as the status changes.

A shared divider makes a 16x oversampling tick from the divisor field. The transmitter runs a four-state machine: `TX_IDLE` goes to `TX_START` when a byte is loaded. `TX_START` goes to `TX_DATA` after 16 ticks. `TX_DATA` goes to `TX_STOP` after the eighth data bit. `TX_STOP` returns to `TX_IDLE` after 16 ticks, and this step raises the done pulse. The receiver also has four states: `RX_IDLE` goes to `RX_START` on a falling edge of the synchronised line while the receiver is enabled. `RX_START` goes to `RX_DATA` after 8 ticks if the line is still low, and otherwise back to `RX_IDLE`. `RX_DATA` goes to `RX_STOP` after the eighth mid-bit sample. `RX_STOP` returns to `RX_IDLE` after 16 ticks and delivers the byte when the stop sample is high. Any state returns to `RX_IDLE` when the receiver is disabled.

Top module: `dbg_uart_top`

## Requirements
- R1: After reset, status reads 0x0000_0202 (TXRDY at bit 1 and TXEMPTY at bit 9 set, RXRDY at bit 0 clear), the mask, mode and divisor read 0, `tx_o` is high and `irq_o` is low.
- R2: Byte offsets are control 0x00, mode 0x04, interrupt set 0x08, interrupt clear 0x0C, mask 0x10, status 0x14, receive 0x18, transmit 0x1C and divisor 0x20. Mode stores all 32 bits. The divisor stores bits 15:0. Control and any unmapped offset read 0.
- R3: A control write with bit 7 set clears TXRDY and TXEMPTY. Otherwise a control write with bit 6 set sets both flags. When both bits are set, the clear wins.
- R4: A transmit write while TXRDY is 1 and the transmitter is idle clears TXRDY and TXEMPTY and starts a frame. A transmit write at any other time is ignored, and the line stays high.
- R5: A frame is one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16×CD clocks, where CD is the divisor. TXRDY and TXEMPTY are set again at the end of the stop bit, about ten bit periods after the load.
- R6: Interrupt-set writes OR bits 0, 1 and 9 of the data into the mask. Interrupt-clear writes clear the mask bits written as 1. Writes to the mask offset have no effect.
- R7: `irq_o` is high exactly while (mask AND status) is non-zero, and it follows status and mask changes.
- R8: A control write with bit 4 set enables the receiver, and one with bit 5 set disables it (disable wins). The receiver is disabled after reset, and while disabled, incoming frames leave the receive byte and RXRDY unchanged.
- R9: An enabled receiver starts on a falling edge and samples each bit at mid-bit. A good frame loads the receive byte and sets RXRDY. Reading the receive offset clears RXRDY.
- R10: A frame that completes while RXRDY is set is dropped, and the receive byte keeps its old value.
- R11: A frame whose stop sample is low is dropped, and the next good frame is still received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while selected |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Level interrupt |

## Verification
Reads return data in the cycle of the access, and a write shows up in status, mask and `irq_o` one clock after its edge. The bench therefore samples one settle delay after the falling edge that follows each access. Transmit bits are checked at the middle of each 32-clock bit period (CD = 2), counted from the load edge. The returning TXRDY is checked once at about 305 clocks, before the 320-clock character time ends, and once at about 326 clocks, after it. Receive status is read only after a whole frame plus idle time has been driven, because RXRDY rises about 9.5 bit periods after the start edge plus two synchroniser clocks.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_MODE  = 6'h04;
    localparam logic [5:0] OFS_IEN   = 6'h08;
    localparam logic [5:0] OFS_IDIS  = 6'h0C;
    localparam logic [5:0] OFS_IMASK = 6'h10;
    localparam logic [5:0] OFS_STAT  = 6'h14;
    localparam logic [5:0] OFS_RHR   = 6'h18;
    localparam logic [5:0] OFS_THR   = 6'h1C;
    localparam logic [5:0] OFS_BAUD  = 6'h20;

    localparam int SB_RXRDY   = 0;
    localparam int SB_TXRDY   = 1;
    localparam int SB_TXEMPTY = 9;

    localparam int CB_RXEN  = 4;
    localparam int CB_RXDIS = 5;
    localparam int CB_TXEN  = 6;
    localparam int CB_TXDIS = 7;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/dbgu_baud.sv
module dbgu_baud #(
    parameter int CD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] cd,
    output logic            tick
);
    logic [CD_W-1:0] cnt_q;
    logic            wrap;

    assign wrap = (cd != '0) && (cnt_q >= cd - CD_W'(1));
    assign tick = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cd == '0)   cnt_q <= '0;
        else if (wrap)       cnt_q <= '0;
        else                 cnt_q <= cnt_q + CD_W'(1);
    end
endmodule

// File: rtl/dbgu_tx.sv
module dbgu_tx
    import dbgu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              done,
    output logic              txd
);
    localparam int TK_W = $clog2(OVS);
    localparam int BC_W = $clog2(DATA_W);

    tx_state_t         state, nxt;
    logic [TK_W-1:0]   tk_cnt;
    logic [BC_W-1:0]   bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              tk_last, bit_last;

    assign tk_last  = (tk_cnt == TK_W'(OVS - 1));
    assign bit_last = (bit_cnt == BC_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load)                          nxt = TX_START;
            TX_START: if (tick && tk_last)               nxt = TX_DATA;
            TX_DATA:  if (tick && tk_last && bit_last)   nxt = TX_STOP;
            TX_STOP:  if (tick && tk_last)               nxt = TX_IDLE;
            default:                                     nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_cnt  <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (state == TX_IDLE) begin
            tk_cnt  <= '0;
            bit_cnt <= '0;
            if (load) shreg <= din;
        end else if (tick) begin
            tk_cnt <= tk_last ? '0 : tk_cnt + TK_W'(1);
            if (state == TX_DATA && tk_last) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_last ? '0 : bit_cnt + BC_W'(1);
            end
        end
    end

    always_comb begin
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && tick && tk_last;
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    p_load_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state == TX_IDLE) |=> (!txd && state == TX_START));
    p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP) |-> txd);
endmodule

// File: rtl/dbgu_rx.sv
module dbgu_rx
    import dbgu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int TK_W = $clog2(OVS);
    localparam int BC_W = $clog2(DATA_W);

    rx_state_t         state, nxt;
    logic              s1, s2, prev;
    logic [TK_W-1:0]   tk_cnt;
    logic [BC_W-1:0]   bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              fall, tk_half, tk_last, bit_last;

    assign fall     = prev && !s2;
    assign tk_half  = (tk_cnt == TK_W'(OVS/2 - 1));
    assign tk_last  = (tk_cnt == TK_W'(OVS - 1));
    assign bit_last = (bit_cnt == BC_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
        end else begin
            s1 <= rxd; s2 <= s1; prev <= s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (fall)                        nxt = RX_START;
            RX_START: if (tick && tk_half)             nxt = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && tk_last && bit_last) nxt = RX_STOP;
            RX_STOP:  if (tick && tk_last)             nxt = RX_IDLE;
            default:                                   nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_cnt  <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (state == RX_IDLE || (state == RX_START && tick && tk_half)) begin
            tk_cnt  <= '0;
            bit_cnt <= '0;
        end else if (tick) begin
            tk_cnt <= tk_last ? '0 : tk_cnt + TK_W'(1);
            if (state == RX_DATA && tk_last) begin
                shreg   <= {s2, shreg[DATA_W-1:1]};
                bit_cnt <= bit_last ? '0 : bit_cnt + BC_W'(1);
            end
        end
    end

    always_comb begin
        valid = en && (state == RX_STOP) && tick && tk_last && s2;
        data  = shreg;
    end

    p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == RX_IDLE));
    p_bad_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && !s2) |-> !valid);
endmodule

// File: rtl/dbg_uart_top.sv
module dbg_uart_top
    import dbgu_pkg::*;
#(
    parameter int CD_W   = 16,
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_i,
    output logic        tx_o,
    output logic        irq_o
);
    localparam logic [31:0] IMPL_BITS = (32'h1 << SB_RXRDY) | (32'h1 << SB_TXRDY)
                                      | (32'h1 << SB_TXEMPTY);

    logic [31:0]       mode_q, imr_q, sr_w;
    logic [CD_W-1:0]   cd_q;
    logic [DATA_W-1:0] rhr_q, thr_q, rx_data;
    logic              rxrdy_q, txrdy_q, txempty_q, rx_en_q;
    logic              tick, tx_busy, tx_done, rx_valid, tx_load;
    logic              wr, rd_rhr;

    assign wr      = bus_sel && bus_we;
    assign rd_rhr  = bus_sel && !bus_we && (bus_addr == OFS_RHR);
    assign tx_load = wr && (bus_addr == OFS_THR) && txrdy_q && !tx_busy;

    dbgu_baud #(.CD_W(CD_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .cd(cd_q), .tick(tick)
    );

    dbgu_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .din(bus_wdata[DATA_W-1:0]), .busy(tx_busy), .done(tx_done), .txd(tx_o)
    );

    dbgu_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en_q), .rxd(rx_i),
        .valid(rx_valid), .data(rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            imr_q     <= '0;
            cd_q      <= '0;
            rhr_q     <= '0;
            thr_q     <= '0;
            rxrdy_q   <= 1'b0;
            txrdy_q   <= 1'b1;
            txempty_q <= 1'b1;
            rx_en_q   <= 1'b0;
        end else begin
            if (tx_done) begin
                txrdy_q   <= 1'b1;
                txempty_q <= 1'b1;
            end
            if (rd_rhr) rxrdy_q <= 1'b0;
            if (rx_valid && !rxrdy_q) begin
                rhr_q   <= rx_data;
                rxrdy_q <= 1'b1;
            end
            if (tx_load) begin
                thr_q     <= bus_wdata[DATA_W-1:0];
                txrdy_q   <= 1'b0;
                txempty_q <= 1'b0;
            end
            if (wr) begin
                unique case (bus_addr)
                    OFS_CTRL: begin
                        if (bus_wdata[CB_TXDIS]) begin
                            txrdy_q   <= 1'b0;
                            txempty_q <= 1'b0;
                        end else if (bus_wdata[CB_TXEN]) begin
                            txrdy_q   <= 1'b1;
                            txempty_q <= 1'b1;
                        end
                        if (bus_wdata[CB_RXDIS])     rx_en_q <= 1'b0;
                        else if (bus_wdata[CB_RXEN]) rx_en_q <= 1'b1;
                    end
                    OFS_MODE: mode_q <= bus_wdata;
                    OFS_IEN:  imr_q  <= imr_q | (bus_wdata & IMPL_BITS);
                    OFS_IDIS: imr_q  <= imr_q & ~bus_wdata;
                    OFS_BAUD: cd_q   <= bus_wdata[CD_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sr_w = '0;
        sr_w[SB_RXRDY]   = rxrdy_q;
        sr_w[SB_TXRDY]   = txrdy_q;
        sr_w[SB_TXEMPTY] = txempty_q;
    end

    assign irq_o = |(imr_q & sr_w);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (bus_addr)
                OFS_MODE:  bus_rdata = mode_q;
                OFS_IMASK: bus_rdata = imr_q;
                OFS_STAT:  bus_rdata = sr_w;
                OFS_RHR:   bus_rdata = 32'(rhr_q);
                OFS_THR:   bus_rdata = 32'(thr_q);
                OFS_BAUD:  bus_rdata = 32'(cd_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    p_txdis_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_CTRL && bus_wdata[CB_TXDIS]) |=> (!txrdy_q && !txempty_q));
    p_txen_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_CTRL && bus_wdata[CB_TXEN] && !bus_wdata[CB_TXDIS])
        |=> (txrdy_q && txempty_q));
    p_thr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (!txrdy_q && !txempty_q && tx_busy));
    p_mask_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_IMASK) |=> $stable(imr_q));
    p_rhr_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rhr && rxrdy_q) |=> !rxrdy_q);
    p_rhr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rxrdy_q |=> $stable(rhr_q));
endmodule

// File: tb/test_dbg_uart_top.sv
module test_dbg_uart_top;
    localparam int CLK_PERIOD = 10;
    localparam int BITP       = 32;   // 16 x CD with CD = 2
    localparam int NV         = 22;

    // {is_read, addr, wdata, expected, requirement}
    localparam logic [74:0] VEC [NV] = '{
        {1'b1, 6'h14, 32'h0,          32'h0000_0202, 4'd1},  // R1 status
        {1'b1, 6'h10, 32'h0,          32'h0,         4'd1},  // R1 mask
        {1'b1, 6'h20, 32'h0,          32'h0,         4'd1},  // R1 divisor
        {1'b0, 6'h04, 32'hA5A5_0001,  32'h0,         4'd2},  // R2 mode write
        {1'b1, 6'h04, 32'h0,          32'hA5A5_0001, 4'd2},
        {1'b0, 6'h20, 32'h1234_0002,  32'h0,         4'd2},  // R2 divisor 16 bits
        {1'b1, 6'h20, 32'h0,          32'h0000_0002, 4'd2},
        {1'b1, 6'h00, 32'h0,          32'h0,         4'd2},  // R2 control reads 0
        {1'b1, 6'h24, 32'h0,          32'h0,         4'd2},  // R2 unmapped
        {1'b0, 6'h08, 32'hFFFF_FFFF,  32'h0,         4'd6},  // R6 set all
        {1'b1, 6'h10, 32'h0,          32'h0000_0203, 4'd6},
        {1'b0, 6'h10, 32'h0,          32'h0,         4'd6},  // R6 mask read-only
        {1'b1, 6'h10, 32'h0,          32'h0000_0203, 4'd6},
        {1'b0, 6'h0C, 32'h0000_0001,  32'h0,         4'd6},  // R6 clear bit 0
        {1'b1, 6'h10, 32'h0,          32'h0000_0202, 4'd6},
        {1'b0, 6'h00, 32'h0000_0080,  32'h0,         4'd3},  // R3 disable
        {1'b1, 6'h14, 32'h0,          32'h0,         4'd3},
        {1'b0, 6'h00, 32'h0000_0040,  32'h0,         4'd3},  // R3 enable
        {1'b1, 6'h14, 32'h0,          32'h0000_0202, 4'd3},
        {1'b0, 6'h00, 32'h0000_00C0,  32'h0,         4'd3},  // R3 both: clear wins
        {1'b1, 6'h14, 32'h0,          32'h0,         4'd3},
        {1'b0, 6'h1C, 32'h0000_0055,  32'h0,         4'd4}   // R4 ignored while TXRDY=0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_i = 1'b1;
    logic        tx_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_uart_top i_dbg_uart_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_i(rx_i), .tx_o(tx_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic send(input logic [7:0] b, input logic stop_bit);
        rx_i = 1'b0;
        repeat (BITP) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            repeat (BITP) @(negedge clk);
        end
        rx_i = stop_bit;
        repeat (BITP) @(negedge clk);
        rx_i = 1'b1;
        repeat (8) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 tx idle high", 32'(tx_o), 32'h1);
        check("R1 irq low", 32'(irq_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][74]) begin
                rd(VEC[i][73:68], d);
                n_chk++;
                if (d !== VEC[i][35:4]) begin
                    n_fail++;
                    $display("FAIL R%0d step %0d: actual 0x%08h expected 0x%08h",
                             VEC[i][3:0], i, d, VEC[i][35:4]);
                end
            end else begin
                wr(VEC[i][73:68], VEC[i][67:36]);
            end
        end
        repeat (40) @(negedge clk);
        #1;
        check("R4 ignored write leaves line high", 32'(tx_o), 32'h1);
        rd(6'h14, d);
        check("R4 ignored write leaves status", d, 32'h0);

        // R7: live interrupt (mask currently holds bits 1 and 9)
        check("R7 irq low while status clear", 32'(irq_o), 32'h0);
        wr(6'h00, 32'h40);
        check("R7 irq follows status set", 32'(irq_o), 32'h1);
        wr(6'h0C, 32'h0000_0202);
        check("R7 irq follows mask clear", 32'(irq_o), 32'h0);

        // R5: transmit frame of 0xA3, CD = 2
        wr(6'h1C, 32'h0000_00A3);
        repeat (15) @(negedge clk);
        #1;
        check("R5 start bit low", 32'(tx_o), 32'h0);
        for (int k = 0; k < 8; k++) begin
            repeat (BITP) @(negedge clk);
            #1;
            check("R5 data bit", 32'(tx_o), 32'((8'hA3 >> k) & 8'h1));
        end
        repeat (BITP) @(negedge clk);
        #1;
        check("R5 stop bit high", 32'(tx_o), 32'h1);
        rd(6'h14, d);
        check("R4 flags clear during frame", d, 32'h0);
        repeat (20) @(negedge clk);
        rd(6'h14, d);
        check("R5 flags back after char time", d, 32'h0000_0202);

        // R8: receiver disabled after reset
        send(8'h3C, 1'b1);
        rd(6'h14, d);
        check("R8 disabled rx no RXRDY", d, 32'h0000_0202);
        rd(6'h18, d);
        check("R8 disabled rx keeps byte", d, 32'h0);

        // R9: enable and receive
        wr(6'h00, 32'h10);
        send(8'h3C, 1'b1);
        rd(6'h14, d);
        check("R9 RXRDY set", d, 32'h0000_0203);
        rd(6'h18, d);
        check("R9 byte received", d, 32'h3C);
        rd(6'h14, d);
        check("R9 read clears RXRDY", d, 32'h0000_0202);

        // R10: second byte dropped while RXRDY set
        send(8'h81, 1'b1);
        send(8'h7E, 1'b1);
        rd(6'h18, d);
        check("R10 old byte kept", d, 32'h81);
        rd(6'h14, d);
        check("R10 RXRDY cleared", d, 32'h0000_0202);

        // R11: bad stop dropped, next frame good
        send(8'h99, 1'b0);
        rd(6'h14, d);
        check("R11 bad stop no RXRDY", d, 32'h0000_0202);
        send(8'h42, 1'b1);
        rd(6'h18, d);
        check("R11 recovery byte", d, 32'h42);

        // R7 with receive flag
        wr(6'h08, 32'h1);
        check("R7 irq low before byte", 32'(irq_o), 32'h0);
        send(8'hE7, 1'b1);
        check("R7 irq on RXRDY", 32'(irq_o), 32'h1);
        rd(6'h18, d);
        check("R7 irq drops after read", 32'(irq_o), 32'h0);

        // R8: disable wins and stops reception
        wr(6'h00, 32'h30);
        send(8'h11, 1'b1);
        rd(6'h14, d);
        check("R8 disabled again no RXRDY", d, 32'h0000_0202);
        rd(6'h18, d);
        check("R8 byte unchanged after disable", d, 32'hE7);

        finish_run();
    end
endmodule